// File: doc/BRIEF.md
# Endpoint STALL and Data-Toggle Controller

This block keeps the per-endpoint handshake state of a USB device function: a STALL request set by firmware, a sticky flag recording that a STALL handshake went out, and the bit that tracks the DATA0/DATA1 sequence. Firmware picks an endpoint by writing an endpoint-number register. Every later register command then acts on that endpoint only: setting or clearing the stall request, clearing the sent flag, or writing the endpoint type. The status outputs also show the state of that endpoint. A per-endpoint reset mask clears the toggle bit, which is what firmware does after a clear-halt request.

The packet engine reports events for one endpoint at a time: a SETUP token, an accepted data packet with its PID, or a STALL that was transmitted. In return the block tells the engine whether that endpoint must answer with STALL. Isochronous endpoints take part in neither STALL handshaking nor toggle tracking. A valid SETUP to a control endpoint drops a pending stall request so that the control transfer can go ahead. The toggle bit has an inverted sense: an accepted DATA0 sets it and an accepted DATA1 clears it.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset, every endpoint has its stall request, sent flag and toggle bit at 0 and its type set to control. The endpoint-number register reads 0 and `irq_o` is 0.
- R2: Type, stall and sent-clear commands act only on the endpoint named by the endpoint-number register, and the `sel_*` outputs show that endpoint. When the number is NUM_EP or higher, commands are ignored and every `sel_*` output reads 0.
- R3: The stall request of the selected endpoint sets on `stall_set_i` and clears on `stall_clr_i`, taking effect after one clock edge. If both are asserted in the same cycle, the clear wins.
- R4: Type encoding: 0 is control, 1 is isochronous, 2 is bulk, 3 is interrupt. On an isochronous endpoint a stall set is ignored, and writing type 1 clears a pending stall request.
- R5: `stall_resp_o` is combinational. It is 1 when the endpoint on `evt_ep_i` has its stall request set and is not isochronous. It is 0 in a cycle that carries `evt_setup_i` to a control endpoint.
- R6: A SETUP event to a control endpoint clears its stall request at the next edge, even if a firmware stall set arrives in the same cycle. A SETUP to a bulk endpoint leaves the request as it is.
- R7: A reported STALL transmission sets the sent flag of a non-isochronous endpoint at the next edge. The flag stays set until firmware clears it. If a clear and a new STALL come in the same cycle, the flag stays set. On an isochronous endpoint the report is ignored.
- R8: `irq_o` is 1 exactly when `int_en_i` is 1 and at least one endpoint has its sent flag set. With the default IRQ_REG=0 it is combinational.
- R9: An accepted data packet (`evt_data_ok_i`) on a non-isochronous endpoint sets the toggle bit when `evt_data1_i`=0 (DATA0) and clears it when `evt_data1_i`=1 (DATA1). On an isochronous endpoint it is ignored, and without `evt_data_ok_i` the bit holds.
- R10: Bit i of `ep_rst_mask_i` clears the toggle bit of endpoint i, and wins over a same-cycle data event. It does not change the stall request or the sent flag, and it does not touch any other endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en_i | input | 1 | Enables the STALL-sent interrupt |
| num_we_i | input | 1 | Write strobe of the endpoint-number register |
| num_wdata_i | input | EP_W | Endpoint number to select |
| num_q_o | output | EP_W | Current endpoint-number register |
| type_we_i | input | 1 | Writes the type of the selected endpoint |
| type_wdata_i | input | 2 | Endpoint type (0 control, 1 iso, 2 bulk, 3 interrupt) |
| stall_set_i | input | 1 | Sets the stall request of the selected endpoint |
| stall_clr_i | input | 1 | Clears the stall request of the selected endpoint |
| sent_clr_i | input | 1 | Clears the sent flag of the selected endpoint |
| ep_rst_mask_i | input | NUM_EP | Per-endpoint toggle reset |
| evt_ep_i | input | EP_W | Endpoint addressed by the packet engine |
| evt_setup_i | input | 1 | SETUP token received |
| evt_data_ok_i | input | 1 | Data packet received and accepted |
| evt_data1_i | input | 1 | PID of the accepted packet: 1 for DATA1, 0 for DATA0 |
| evt_stall_sent_i | input | 1 | A STALL handshake was transmitted |
| stall_resp_o | output | 1 | Answer the addressed endpoint with STALL |
| sel_stall_req_o | output | 1 | Stall request of the selected endpoint |
| sel_sent_o | output | 1 | Sent flag of the selected endpoint |
| sel_toggle_o | output | 1 | Toggle bit of the selected endpoint |
| sel_type_o | output | 2 | Type of the selected endpoint |
| irq_o | output | 1 | Interrupt request |

## Verification
A stall request left set in error shows on `stall_resp_o` in the very cycle the engine addresses that endpoint. A request that failed to clear on SETUP shows one edge after that SETUP. A wrong sent flag or toggle bit reaches `sel_sent_o`, `sel_toggle_o` and `irq_o` one clock edge after the event that corrupted it. Writes that land on the wrong endpoint can only be seen after the endpoint-number register is moved, so the tests reselect neighbouring endpoints and out-of-range numbers and read their state back.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
   typedef enum logic [1:0] {
      EPK_CTRL = 2'd0,
      EPK_ISO  = 2'd1,
      EPK_BULK = 2'd2,
      EPK_INTR = 2'd3
   } ep_kind_e;
endpackage

// File: rtl/ep_hs_slot.sv
module ep_hs_slot
   import ep_hs_pkg::*;
#(
   parameter ep_kind_e RST_KIND = EPK_CTRL
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_hit,
   input  logic     evt_hit,
   input  logic     type_we,
   input  ep_kind_e type_wdata,
   input  logic     stall_set,
   input  logic     stall_clr,
   input  logic     sent_clr,
   input  logic     ep_rst,
   input  logic     evt_setup,
   input  logic     evt_data_ok,
   input  logic     evt_data1,
   input  logic     evt_stall_sent,
   output logic     req_o,
   output logic     sent_o,
   output logic     tog_o,
   output ep_kind_e kind_o
);
   ep_kind_e kind_q, kind_d;
   logic     req_q, req_d;
   logic     sent_q, sent_d;
   logic     tog_q, tog_d;
   logic     is_iso, is_ctrl, setup_hit;

   assign is_iso    = (kind_q == EPK_ISO);
   assign is_ctrl   = (kind_q == EPK_CTRL);
   assign setup_hit = evt_hit & evt_setup & is_ctrl;

   always_comb begin
      kind_d = kind_q;
      if (sel_hit && type_we) kind_d = type_wdata;
   end

   // stall request: SETUP beats firmware, clear beats set
   always_comb begin
      req_d = req_q;
      if (setup_hit)                             req_d = 1'b0;
      else if (sel_hit && stall_clr)             req_d = 1'b0;
      else if (sel_hit && stall_set && !is_iso)  req_d = 1'b1;
      if (sel_hit && type_we && type_wdata == EPK_ISO) req_d = 1'b0;
   end

   // sent flag: a new STALL beats the firmware clear
   always_comb begin
      sent_d = sent_q;
      if (evt_hit && evt_stall_sent && !is_iso) sent_d = 1'b1;
      else if (sel_hit && sent_clr)              sent_d = 1'b0;
   end

   // toggle: endpoint reset beats a data event; DATA0 sets, DATA1 clears
   always_comb begin
      tog_d = tog_q;
      if (ep_rst)                                tog_d = 1'b0;
      else if (evt_hit && evt_data_ok && !is_iso) tog_d = ~evt_data1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= RST_KIND;
         req_q  <= 1'b0;
         sent_q <= 1'b0;
         tog_q  <= 1'b0;
      end else begin
         kind_q <= kind_d;
         req_q  <= req_d;
         sent_q <= sent_d;
         tog_q  <= tog_d;
      end
   end

   assign req_o  = req_q;
   assign sent_o = sent_q;
   assign tog_o  = tog_q;
   assign kind_o = kind_q;

   assert_iso_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == EPK_ISO) |-> !req_q);

   assert_setup_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_hit && evt_setup && kind_q == EPK_CTRL) |=> !req_q);

   assert_sent_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_hit && evt_stall_sent && kind_q != EPK_ISO) |=> sent_q);

   assert_sent_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sent_q && !(sel_hit && sent_clr)) |=> sent_q);

   assert_data0_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_hit && evt_data_ok && !evt_data1 && kind_q != EPK_ISO && !ep_rst) |=> tog_q);

   assert_eprst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ep_rst |=> !tog_q);

   assert_eprst_keeps_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_rst && !sel_hit && !evt_hit) |=> ($stable(req_q) && $stable(sent_q)));
endmodule

// File: rtl/ep_hs_irq.sv
module ep_hs_irq #(
   parameter int N       = 7,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] flags,
   output logic         irq_o
);
   logic any_w;
   assign any_w = en & (|flags);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_w;
         end
         assign irq_o = irq_q;
         assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o == $past(any_w));
      end else begin : g_comb
         assign irq_o = any_w;
         assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> (en && flags != '0));
      end
   endgenerate
endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
   import ep_hs_pkg::*;
#(
   parameter int NUM_EP  = 7,
   parameter int EP_W    = 3,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_en_i,
   input  logic              num_we_i,
   input  logic [EP_W-1:0]   num_wdata_i,
   output logic [EP_W-1:0]   num_q_o,
   input  logic              type_we_i,
   input  logic [1:0]        type_wdata_i,
   input  logic              stall_set_i,
   input  logic              stall_clr_i,
   input  logic              sent_clr_i,
   input  logic [NUM_EP-1:0] ep_rst_mask_i,
   input  logic [EP_W-1:0]   evt_ep_i,
   input  logic              evt_setup_i,
   input  logic              evt_data_ok_i,
   input  logic              evt_data1_i,
   input  logic              evt_stall_sent_i,
   output logic              stall_resp_o,
   output logic              sel_stall_req_o,
   output logic              sel_sent_o,
   output logic              sel_toggle_o,
   output logic [1:0]        sel_type_o,
   output logic              irq_o
);
   localparam int EP_SPAN = 1 << EP_W;

   generate
      if (NUM_EP < 1 || NUM_EP > EP_SPAN) begin : g_bad_cfg
         $error("ep_handshake_ctrl: NUM_EP does not fit in EP_W bits");
      end
   endgenerate

   logic [EP_W-1:0]   num_q;
   logic [NUM_EP-1:0] req_v, sent_v, tog_v;
   ep_kind_e          kind_v [NUM_EP];

   always_ff @(posedge clk) begin
      if (!rst_n)        num_q <= '0;
      else if (num_we_i) num_q <= num_wdata_i;
   end
   assign num_q_o = num_q;

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         ep_hs_slot #(.RST_KIND(EPK_CTRL)) u_slot (
            .clk            (clk),
            .rst_n          (rst_n),
            .sel_hit        (num_q == EP_W'(i)),
            .evt_hit        (evt_ep_i == EP_W'(i)),
            .type_we        (type_we_i),
            .type_wdata     (ep_kind_e'(type_wdata_i)),
            .stall_set      (stall_set_i),
            .stall_clr      (stall_clr_i),
            .sent_clr       (sent_clr_i),
            .ep_rst         (ep_rst_mask_i[i]),
            .evt_setup      (evt_setup_i),
            .evt_data_ok    (evt_data_ok_i),
            .evt_data1      (evt_data1_i),
            .evt_stall_sent (evt_stall_sent_i),
            .req_o          (req_v[i]),
            .sent_o         (sent_v[i]),
            .tog_o          (tog_v[i]),
            .kind_o         (kind_v[i])
         );
      end
   endgenerate

   always_comb begin
      sel_stall_req_o = 1'b0;
      sel_sent_o      = 1'b0;
      sel_toggle_o    = 1'b0;
      sel_type_o      = 2'd0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (num_q == EP_W'(i)) begin
            sel_stall_req_o = req_v[i];
            sel_sent_o      = sent_v[i];
            sel_toggle_o    = tog_v[i];
            sel_type_o      = kind_v[i];
         end
      end
   end

   always_comb begin
      stall_resp_o = 1'b0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (evt_ep_i == EP_W'(i)) begin
            stall_resp_o = req_v[i] && (kind_v[i] != EPK_ISO) &&
                           !(evt_setup_i && kind_v[i] == EPK_CTRL);
         end
      end
   end

   ep_hs_irq #(.N(NUM_EP), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (int_en_i),
      .flags (sent_v),
      .irq_o (irq_o)
   );

   assert_resp_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stall_resp_o |-> !evt_setup_i || (sel_type_o != 2'd0) || (num_q != evt_ep_i));

   assert_oor_select_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(num_q) >= NUM_EP) |-> !(sel_stall_req_o || sel_sent_o || sel_toggle_o));
endmodule

// File: tb/tb_ep_handshake_ctrl.sv
module tb_ep_handshake_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_EP = 7;
   localparam int EP_W   = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic int_en, num_we, type_we, stall_set, stall_clr, sent_clr;
   logic [EP_W-1:0] num_wdata, evt_ep;
   logic [1:0] type_wdata;
   logic [NUM_EP-1:0] ep_rst_mask;
   logic evt_setup, evt_data_ok, evt_data1, evt_stall_sent;
   logic [EP_W-1:0] num_q;
   logic stall_resp, sel_req, sel_sent, sel_tog, irq;
   logic [1:0] sel_type;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep_handshake_ctrl #(.NUM_EP(NUM_EP), .EP_W(EP_W)) dut (
      .clk(clk), .rst_n(rst_n), .int_en_i(int_en),
      .num_we_i(num_we), .num_wdata_i(num_wdata), .num_q_o(num_q),
      .type_we_i(type_we), .type_wdata_i(type_wdata),
      .stall_set_i(stall_set), .stall_clr_i(stall_clr), .sent_clr_i(sent_clr),
      .ep_rst_mask_i(ep_rst_mask), .evt_ep_i(evt_ep), .evt_setup_i(evt_setup),
      .evt_data_ok_i(evt_data_ok), .evt_data1_i(evt_data1),
      .evt_stall_sent_i(evt_stall_sent), .stall_resp_o(stall_resp),
      .sel_stall_req_o(sel_req), .sel_sent_o(sel_sent), .sel_toggle_o(sel_tog),
      .sel_type_o(sel_type), .irq_o(irq)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      num_we = 0; num_wdata = '0; type_we = 0; type_wdata = '0;
      stall_set = 0; stall_clr = 0; sent_clr = 0; ep_rst_mask = '0;
      evt_ep = '0; evt_setup = 0; evt_data_ok = 0; evt_data1 = 0;
      evt_stall_sent = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1; idle();
   endtask

   task automatic sel(int n);
      num_we = 1; num_wdata = EP_W'(n); tick();
   endtask

   task automatic set_type(int n, int k);
      sel(n); type_we = 1; type_wdata = 2'(k); tick();
   endtask

   task automatic t_reset();
      chk("R1 num", int'(num_q), 0);
      for (int e = 0; e < NUM_EP; e++) begin
         sel(e);
         chk("R1 req", int'(sel_req), 0);
         chk("R1 sent", int'(sel_sent), 0);
         chk("R1 tog", int'(sel_tog), 0);
         chk("R1 type", int'(sel_type), 0);
      end
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_select();
      set_type(2, 2);
      sel(3); chk("R2 other type", int'(sel_type), 0);
      sel(2); chk("R2 own type", int'(sel_type), 2);
      sel(7); stall_set = 1; tick();
      type_we = 1; type_wdata = 2'd3; tick();
      chk("R2 oor type", int'(sel_type), 0);
      chk("R2 oor req", int'(sel_req), 0);
      for (int e = 0; e < NUM_EP; e++) begin
         evt_ep = EP_W'(e); #1;
         chk("R2 no stray stall", int'(stall_resp), 0);
      end
      idle();
   endtask

   task automatic t_stall();
      sel(1); stall_set = 1; tick();
      chk("R3 set", int'(sel_req), 1);
      evt_ep = 3'd1; #1; chk("R5 resp own", int'(stall_resp), 1);
      evt_ep = 3'd2; #1; chk("R5 resp other", int'(stall_resp), 0);
      idle();
      stall_set = 1; stall_clr = 1; tick();
      chk("R3 clear wins", int'(sel_req), 0);
      set_type(4, 1); stall_set = 1; tick();
      chk("R4 iso ignores set", int'(sel_req), 0);
      set_type(5, 2); stall_set = 1; tick();
      chk("R4 bulk set", int'(sel_req), 1);
      type_we = 1; type_wdata = 2'd1; tick();
      chk("R4 iso write drops req", int'(sel_req), 0);
      evt_ep = 3'd5; #1; chk("R5 iso no resp", int'(stall_resp), 0);
      idle();
   endtask

   task automatic t_setup();
      sel(1); stall_set = 1; tick();
      evt_ep = 3'd1; evt_setup = 1; #1;
      chk("R5 setup masks resp", int'(stall_resp), 0);
      tick(); chk("R6 setup clears", int'(sel_req), 0);
      stall_set = 1; evt_ep = 3'd1; evt_setup = 1; tick();
      chk("R6 setup beats set", int'(sel_req), 0);
      sel(2); stall_set = 1; tick();
      evt_ep = 3'd2; evt_setup = 1; #1;
      chk("R5 bulk setup resp", int'(stall_resp), 1);
      tick(); chk("R6 bulk keeps", int'(sel_req), 1);
   endtask

   task automatic t_sent();
      int_en = 0;
      sel(2);
      evt_ep = 3'd2; evt_stall_sent = 1; tick();
      chk("R7 sent set", int'(sel_sent), 1);
      chk("R8 irq masked", int'(irq), 0);
      int_en = 1; #1; chk("R8 irq on", int'(irq), 1);
      evt_ep = 3'd2; evt_stall_sent = 1; sent_clr = 1; tick();
      chk("R7 set beats clear", int'(sel_sent), 1);
      sent_clr = 1; tick();
      chk("R7 cleared", int'(sel_sent), 0);
      chk("R8 irq off", int'(irq), 0);
      evt_ep = 3'd4; evt_stall_sent = 1; tick();
      sel(4); chk("R7 iso ignored", int'(sel_sent), 0);
      chk("R8 irq stays off", int'(irq), 0);
      int_en = 0;
   endtask

   task automatic t_toggle();
      sel(2);
      evt_ep = 3'd2; evt_data_ok = 1; evt_data1 = 0; tick();
      chk("R9 data0 sets", int'(sel_tog), 1);
      evt_ep = 3'd2; evt_data_ok = 1; evt_data1 = 1; tick();
      chk("R9 data1 clears", int'(sel_tog), 0);
      evt_ep = 3'd2; evt_data_ok = 0; evt_data1 = 0; tick();
      chk("R9 needs accept", int'(sel_tog), 0);
      evt_ep = 3'd4; evt_data_ok = 1; evt_data1 = 0; tick();
      sel(4); chk("R9 iso ignored", int'(sel_tog), 0);
   endtask

   task automatic t_ep_reset();
      sel(2);
      evt_ep = 3'd2; evt_data_ok = 1; tick();
      chk("R9 setup tog", int'(sel_tog), 1);
      ep_rst_mask = 7'b0001000; tick();
      chk("R10 other ep untouched", int'(sel_tog), 1);
      ep_rst_mask = 7'b0000100; evt_ep = 3'd2; evt_data_ok = 1; tick();
      chk("R10 reset wins", int'(sel_tog), 0);
      chk("R10 req kept", int'(sel_req), 1);
   endtask

   initial begin
      idle(); int_en = 0; rst_n = 0;
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      t_reset();
      t_select();
      t_stall();
      t_setup();
      t_sent();
      t_toggle();
      t_ep_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule